// File: doc/BRIEF.md
# Legacy Shadow Window Router

This block decides, for every memory access that falls into the legacy window from 768 KB up to 1 MB, whether the access is served by DRAM or is passed on to the memory-mapped I/O side. The window is split into twelve 16 KB segments from 0xC0000 to 0xEFFFF and one 64 KB segment from 0xF0000 to 0xFFFFF. Each segment has a 2-bit attribute code. The code treats reads and writes separately, so firmware can shadow a ROM image by making a segment write-only to DRAM, copying the image, and then making it read-only.

The thirteen codes are kept in seven 8-bit attribute registers that are loaded through a small write port (write enable, register index, data byte). Register 0 holds only the code for the 64 KB top segment. Registers 1 to 6 each hold the codes for two neighbouring 16 KB segments. The routing decision is combinational from the access address and its direction. Addresses outside the window always go to DRAM.

Top module: `shadow_window_router`

## Requirements
- R1: After a synchronous reset every attribute code is 00, so every read and write inside 0xC0000–0xFFFFF is routed away from DRAM (acc_to_dram = 0).
- R2: Code 00 routes both reads and writes of its segment to memory-mapped I/O (acc_to_dram = 0).
- R3: Code 01 routes reads to DRAM (acc_to_dram = 1) and writes to memory-mapped I/O (acc_to_dram = 0).
- R4: Code 10 routes writes to DRAM and reads to memory-mapped I/O.
- R5: Code 11 routes both reads and writes to DRAM.
- R6: An address below 0xC0000 or above 0xFFFFF gives acc_to_dram = 1 for both directions, whatever the attribute contents are.
- R7: Bits [5:4] of register 0 hold the code for 0xF0000–0xFFFFF. Bits [3:0] and [7:6] of register 0 have no effect on routing.
- R8: Register n (1 to 6) covers the 32 KB from 0xC0000 + (n−1)·0x8000. Bits [1:0] hold the code for its lower 16 KB and bits [5:4] hold the code for its upper 16 KB. Bits [3:2] and [7:6] have no effect.
- R9: A write on the port takes effect from the next clock edge. An access in the same cycle as a write to its own segment is routed by the old code.
- R10: A write with an index of 7 or more changes no routing decision.
- R11: Writing 0x30 to register 0 and 0x33 to registers 1–6 routes the whole window to DRAM for reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Attribute register write enable |
| cfg_idx | input | IDX_W (3) | Attribute register index |
| cfg_wdata | input | 8 | Attribute register write data |
| acc_addr | input | ADDR_W (32) | Byte address of the current access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_to_dram | output | 1 | 1 = route the access to DRAM, 0 = route it to memory-mapped I/O |

## Verification
A configuration write and an access to the segment that the write is changing can happen in the same cycle. The bench sets up this collision on purpose. In the same cycle it writes a new code to a register and reads or writes an address that the register covers. Its reference model applies the write only after the clock edge, so the bench expects the old routing during the collision cycle and the new routing in the cycle after it. Each cycle is compared against the model, and the sweeps cover both the boundary addresses of every segment and addresses just outside the window.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [1:0] {
    ATTR_OFF = 2'b00,
    ATTR_RD  = 2'b01,
    ATTR_WR  = 2'b10,
    ATTR_RW  = 2'b11
  } attr_code_t;

  localparam int unsigned ATTR_REGS   = 7;
  localparam int unsigned ATTR_DATA_W = 8;
  localparam int unsigned LO_LSB      = 0;
  localparam int unsigned HI_LSB      = 4;
  localparam int unsigned WIN_BASE    = 32'h000C_0000;
  localparam int unsigned WIN_TOP     = 32'h000F_FFFF;

endpackage

// File: rtl/shadow_attr_store.sv
module shadow_attr_store
  import shadow_pkg::*;
#(
  parameter int unsigned NUM_REGS = ATTR_REGS,
  parameter int unsigned DATA_W   = ATTR_DATA_W,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_REGS-1:0][1:0] lo_q,
  output logic [NUM_REGS-1:0][1:0] hi_q
);

  logic idx_ok;
  assign idx_ok = (int'(wr_idx) < int'(NUM_REGS));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && idx_ok && (int'(wr_idx) == g);

    // Upper field exists in every register
    always_ff @(posedge clk) begin
      if (rst)      hi_q[g] <= ATTR_OFF;
      else if (hit) hi_q[g] <= wr_data[HI_LSB+1:HI_LSB];
    end

    if (g == 0) begin : g_top_reg
      // Register 0 has only the 64 KB segment field; low bits are reserved
      assign lo_q[g] = ATTR_OFF;
    end else begin : g_pair_reg
      always_ff @(posedge clk) begin
        if (rst)      lo_q[g] <= ATTR_OFF;
        else if (hit) lo_q[g] <= wr_data[LO_LSB+1:LO_LSB];
      end
    end
  end

  // R10
  bad_index_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(int'(wr_idx) < int'(NUM_REGS))) |=> ($stable(lo_q) && $stable(hi_q)));

  // R9
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_idx) < int'(NUM_REGS))) |=>
      (hi_q[$past(wr_idx)] == $past(wr_data[HI_LSB+1:HI_LSB])));

endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_REGS = ATTR_REGS,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [IDX_W-1:0]  reg_sel,
  output logic              hi_sel
);

  localparam int unsigned MB_BIT = 20;

  logic above_1mb;
  logic top_seg;

  if (ADDR_W > MB_BIT) begin : g_wide
    assign above_1mb = |addr[ADDR_W-1:MB_BIT];
  end else begin : g_narrow
    assign above_1mb = 1'b0;
  end

  // 0xC0000-0xFFFFF: address bits 19:18 both set, nothing above bit 19
  assign in_win  = !above_1mb && (addr[19:18] == 2'b11);
  assign top_seg = (addr[17:16] == 2'b11);

  always_comb begin
    if (top_seg) begin
      reg_sel = '0;
      hi_sel  = 1'b1;
    end else begin
      // 16 KB segment k = addr[17:14]; pair register = 1 + k/2
      reg_sel = IDX_W'(addr[17:15]) + IDX_W'(1);
      hi_sel  = addr[14];
    end
  end

endmodule

// File: rtl/shadow_route_rule.sv
module shadow_route_rule
  import shadow_pkg::*;
(
  input  logic [1:0] code,
  input  logic       is_write,
  output logic       take_dram
);

  attr_code_t c;
  assign c = attr_code_t'(code);

  always_comb begin
    unique case (c)
      ATTR_OFF: take_dram = 1'b0;
      ATTR_RD:  take_dram = !is_write;
      ATTR_WR:  take_dram = is_write;
      ATTR_RW:  take_dram = 1'b1;
      default:  take_dram = 1'b0;
    endcase
  end

endmodule

// File: rtl/shadow_window_router.sv
module shadow_window_router
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_REGS = ATTR_REGS,
  parameter int unsigned DATA_W   = ATTR_DATA_W,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              acc_to_dram
);

  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_TOP);

  logic [NUM_REGS-1:0][1:0] lo_q;
  logic [NUM_REGS-1:0][1:0] hi_q;
  logic                     in_win;
  logic [IDX_W-1:0]         reg_sel;
  logic                     hi_sel;
  logic [1:0]               sel_code;
  logic                     rule_dram;

  shadow_attr_store #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .lo_q    (lo_q),
    .hi_q    (hi_q)
  );

  shadow_seg_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr    (acc_addr),
    .in_win  (in_win),
    .reg_sel (reg_sel),
    .hi_sel  (hi_sel)
  );

  always_comb begin
    sel_code = ATTR_OFF;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      if (int'(reg_sel) == r) sel_code = hi_sel ? hi_q[r] : lo_q[r];
    end
  end

  shadow_route_rule u_rule (
    .code      (sel_code),
    .is_write  (acc_write),
    .take_dram (rule_dram)
  );

  assign acc_to_dram = !in_win || rule_dram;

  // R6
  outside_window_chk: assert property (@(posedge clk) disable iff (rst)
    ((acc_addr < WIN_LO) || (acc_addr > WIN_HI)) |-> acc_to_dram);

  // R2
  off_code_chk: assert property (@(posedge clk) disable iff (rst)
    ((acc_addr >= WIN_LO) && (acc_addr <= WIN_HI) && (sel_code == ATTR_OFF)) |-> !acc_to_dram);

  // R5
  rw_code_chk: assert property (@(posedge clk) disable iff (rst)
    ((acc_addr >= WIN_LO) && (acc_addr <= WIN_HI) && (sel_code == ATTR_RW)) |-> acc_to_dram);

endmodule

// File: tb/shadow_window_router_test.sv
module shadow_window_router_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int IDX_W      = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [IDX_W-1:0]  cfg_idx = '0;
  logic [7:0]        cfg_wdata = '0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              acc_write = 1'b0;
  logic              acc_to_dram;

  int checks = 0;
  int errors = 0;
  int mdl [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_window_router uut (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_wdata   (cfg_wdata),
    .acc_addr    (acc_addr),
    .acc_write   (acc_write),
    .acc_to_dram (acc_to_dram)
  );

  function automatic logic expect_dram(longint a, logic wr);
    int code;
    int k;
    if (a < 64'h0C0000 || a > 64'h0FFFFF) return 1'b1;
    if (a >= 64'h0F0000) code = (mdl[0] >> 4) & 3;
    else begin
      k = int'((a - 64'h0C0000) / 64'h4000);
      code = (k % 2 == 1) ? ((mdl[1 + k/2] >> 4) & 3) : (mdl[1 + k/2] & 3);
    end
    return wr ? logic'((code >> 1) & 1) : logic'(code & 1);
  endfunction

  task automatic step(input string tag, input logic we, input int idx, input int data,
                      input longint a, input logic wr);
    logic e;
    cfg_we    = we;
    cfg_idx   = IDX_W'(idx);
    cfg_wdata = 8'(data);
    acc_addr  = ADDR_W'(a);
    acc_write = wr;
    #1;
    e = expect_dram(a, wr);
    checks++;
    if (acc_to_dram !== e) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0b got %0b expected %0b", tag, a, wr, acc_to_dram, e);
    end
    @(posedge clk);
    if (we && idx < 7) mdl[idx] = data;
    @(negedge clk);
  endtask

  task automatic cfg(input string tag, input int idx, input int data);
    step(tag, 1'b1, idx, data, 64'h0, 1'b0);
  endtask

  task automatic sweep(input string tag);
    longint lo;
    longint hi;
    for (int s = 0; s < 13; s++) begin
      lo = (s < 12) ? 64'h0C0000 + s * 64'h4000 : 64'h0F0000;
      hi = (s < 12) ? lo + 64'h3FFF : 64'h0FFFFF;
      for (int w = 0; w < 2; w++) begin
        step(tag, 1'b0, 0, 0, lo, logic'(w));
        step(tag, 1'b0, 0, 0, hi, logic'(w));
      end
    end
    for (int w = 0; w < 2; w++) begin
      step({tag, " R6"}, 1'b0, 0, 0, 64'h0BFFFF, logic'(w));
      step({tag, " R6"}, 1'b0, 0, 0, 64'h100000, logic'(w));
      step({tag, " R6"}, 1'b0, 0, 0, 64'h0, logic'(w));
      step({tag, " R6"}, 1'b0, 0, 0, 64'hFFFC0000, logic'(w));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 7; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state across the whole window, R6 outside
    sweep("R1");

    // R3 / R4 / R8: register 1 lower=01, upper=10, reserved bits set
    cfg("R8", 1, 8'hEE & 8'hCC | 8'h21);
    sweep("R3 R4 R8");

    // R7: register 0 reserved bits only -> F segment stays off
    cfg("R7", 0, 8'hCF);
    sweep("R7");
    cfg("R7", 0, 8'h10);
    sweep("R7 R3");
    cfg("R7", 0, 8'hA0);
    sweep("R7 R4");

    // R8: reserved bits of a pair register have no effect
    cfg("R8", 3, 8'hCC);
    sweep("R8");

    // R10: out-of-range index changes nothing
    step("R10", 1'b1, 7, 8'hFF, 64'h0D8000, 1'b0);
    sweep("R10");

    // R9: write and access to the same segment in one cycle
    step("R9", 1'b1, 2, 8'h33, 64'h0C8000, 1'b0);
    step("R9", 1'b0, 0, 0, 64'h0C8000, 1'b0);
    step("R9", 1'b1, 2, 8'h00, 64'h0CC000, 1'b1);
    step("R9", 1'b0, 0, 0, 64'h0CC000, 1'b1);
    step("R9", 1'b1, 0, 8'h20, 64'h0FFFFF, 1'b1);
    step("R9", 1'b0, 0, 0, 64'h0FFFFF, 1'b1);

    // R11 / R5: full read/write map
    cfg("R11", 0, 8'h30);
    for (int r = 1; r < 7; r++) cfg("R11", r, 8'h33);
    sweep("R11 R5");

    // R2: return one register to code 00
    cfg("R2", 4, 8'h00);
    sweep("R2");

    // mixed per-register patterns
    for (int r = 1; r < 7; r++) cfg("R8", r, ((r & 3) << 4) | ((r + 1) & 3));
    sweep("R3 R4 R5 R8");

    // R1: reset again clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 7; i++) mdl[i] = 0;
    sweep("R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule